// File: doc/BRIEF.md
# Bus Controller Instruction Sequencer

This block runs a serial-bus controller without help from the host processor. It steps through an instruction list kept in shared memory. Each list entry is two words: an opcode followed by a parameter. For a message entry, the parameter is the base address of a message descriptor. The sequencer reads the descriptor's control and command words and presents them to a message engine. It starts the engine with a one-cycle pulse and waits for the engine's done pulse. It then stores the engine's result words back into the same descriptor and moves on to the next entry.

The host loads a start address while the block is idle, pulses `go`, and can read the live instruction address at any time. A message may ask for one automatic retry. If the first attempt reports failure, the message is issued once more on the other bus channel. Jump entries redirect the list. A halt entry, or any unknown opcode, stops the sequencer.

Memory is a synchronous port. A read request placed in one cycle returns its data in the next cycle. The states are IDLE, OP_RD (read the opcode), PAR_RD (capture the opcode and read the parameter), DECODE, DESC_RD / DESC_CAP (read and capture one descriptor word per pair of cycles), START (pulse the engine), WAIT (wait for done) and WB (write back one result word per cycle). The transitions are:

- IDLE to OP_RD on `go`.
- OP_RD to PAR_RD, then PAR_RD to DECODE.
- DECODE to IDLE on halt or on an unknown opcode.
- DECODE to OP_RD on jump.
- DECODE to DESC_RD on a message.
- DESC_CAP back to DESC_RD until the last descriptor word, then on to START.
- START to WAIT.
- WAIT to START for a retry, or to WB otherwise.
- WB to OP_RD after the last write.

Top module: `bc_seq_top`

## Requirements
- R1: A host pointer write while idle sets the instruction address, and `cur_ptr` shows that value. A `go` pulse starts execution at that address, and `running` stays high until the sequencer stops.
- R2: An entry's opcode is read at the instruction address and its parameter at the address plus 1. The opcode encodings are 0 = halt, 1 = message and 2 = jump.
- R3: For a message, descriptor words at offsets 0 (control), 1 (command), 2 (data pointer) and 3 (time to next message) are presented on the `msg_*` outputs. If control bit 0 is set (an RT-to-RT transfer), offset 8 is also read as the second command. `msg_start` is then a single-cycle pulse.
- R4: While a message is in progress, the instruction address does not change. It advances by exactly 2 only after the done pulse and the write-back have finished.
- R5: After completion, the result words are written to these descriptor offsets: time tag to 4, block status to 5, loopback to 6 and RT status to 7. For an RT-to-RT transfer, the second RT status is also written to offset 9. No other descriptor word is written.
- R6: Control bit 1 selects the bus channel (`msg_chan`). If control bit 2 (retry) is set and the done pulse comes with `msg_fail`, the message is issued exactly once more on the other channel. The final attempt's results are the ones written back.
- R7: A jump sets the instruction address to its parameter and continues fetching there.
- R8: A halt clears `running` and leaves the instruction address pointing at the halt entry.
- R9: An unknown opcode stops the sequencer with `err` set and the address left at that entry. The next `go` clears `err`.
- R10: A host pointer write while `running` is high is ignored.
- R11: The number of messages run back to back is limited only by the list contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_ptr_we | input | 1 | Host write strobe for the start address |
| host_ptr_wdata | input | AW | Start address value |
| host_go | input | 1 | Start pulse |
| cur_ptr | output | AW | Live instruction address (read-only) |
| running | output | 1 | High while the sequencer is active |
| err | output | 1 | Unknown opcode seen |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after the request |
| msg_start | output | 1 | Message start pulse |
| msg_ctrl | output | DW | Descriptor control word |
| msg_cmd | output | DW | Command word (the receive command for RT-to-RT) |
| msg_dptr | output | DW | Data block pointer |
| msg_ttnm | output | DW | Time to next message |
| msg_cmd2 | output | DW | Transmit command for RT-to-RT |
| msg_chan | output | 1 | Bus channel for this attempt |
| msg_done | input | 1 | Message completion pulse |
| msg_fail | input | 1 | Failure status, valid with `msg_done` |
| msg_ttag | input | DW | Result time tag |
| msg_bstat | input | DW | Result block status |
| msg_loop | input | DW | Result loopback word |
| msg_rtstat | input | DW | Result RT status |
| msg_rtstat2 | input | DW | Result second RT status |

## Verification
The bench builds the block with AW = 8 and DW = 16. This gives a 256-word memory model, so instruction lists, jump targets and both the 8-word and 10-word descriptor layouts sit at small, visible addresses. The modelled message engine answers after a fixed latency of six cycles. That leaves room to check the address-hold rule and an ignored host write while a message is in progress. A per-test failure mask then drives the retry path through first-attempt failure, second-attempt failure and retry-disabled cases.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_OP_RD, S_PAR_RD, S_DECODE,
        S_DESC_RD, S_DESC_CAP, S_START, S_WAIT, S_WB
    } seq_state_e;

    localparam int OPC_HALT  = 0;
    localparam int OPC_MSG   = 1;
    localparam int OPC_JUMP  = 2;

    localparam int CTL_RT2RT = 0;
    localparam int CTL_CHAN  = 1;
    localparam int CTL_RETRY = 2;

    localparam int N_DESC_IN  = 5;
    localparam int N_RESULT   = 5;
    localparam int OFF_CMD2   = 8;
    localparam int OFF_RES0   = 4;
    localparam int OFF_RTSTAT2 = 9;
endpackage

// File: rtl/seq_ptr.sv
module seq_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          jump,
    input  logic [AW-1:0] jump_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] STEP = AW'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (jump) ptr <= jump_val;
        else if (inc)  ptr <= ptr + STEP;
    end

    assert_step_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && !jump) |=> (ptr == $past(ptr) + STEP));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_go,
    input  logic [AW-1:0] ptr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          msg_done,
    input  logic          msg_fail,
    input  logic [DW-1:0] res_in [N_RESULT],
    output logic          ptr_inc,
    output logic          ptr_jump,
    output logic [AW-1:0] jump_val,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          msg_start,
    output logic [DW-1:0] desc_out [N_DESC_IN],
    output logic          msg_chan,
    output logic          running,
    output logic          err,
    output logic          msg_active
);
    localparam int IW = 3;

    seq_state_e    state_q, state_d;
    logic [DW-1:0] op_q, par_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] dw_q  [N_DESC_IN];
    logic [DW-1:0] res_q [N_RESULT];
    logic          chan_q, retried_q, err_q;

    logic          rt2rt, retry_now, last_xfer, op_known;
    logic [IW-1:0] n_xfer;
    logic [3:0]    rd_off, wb_off;
    logic [AW-1:0] base;

    assign rt2rt     = dw_q[0][CTL_RT2RT];
    assign n_xfer    = rt2rt ? IW'(5) : IW'(4);
    assign last_xfer = (idx_q + IW'(1)) == n_xfer;
    assign retry_now = msg_fail && dw_q[0][CTL_RETRY] && !retried_q;
    assign rd_off    = (idx_q < IW'(4)) ? {1'b0, idx_q} : 4'(OFF_CMD2);
    assign wb_off    = (idx_q < IW'(4)) ? 4'(OFF_RES0) + {1'b0, idx_q} : 4'(OFF_RTSTAT2);
    assign base      = par_q[AW-1:0];
    assign op_known  = (op_q == DW'(OPC_HALT)) || (op_q == DW'(OPC_MSG)) ||
                       (op_q == DW'(OPC_JUMP));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (host_go) state_d = S_OP_RD;
            S_OP_RD:    state_d = S_PAR_RD;
            S_PAR_RD:   state_d = S_DECODE;
            S_DECODE: begin
                if (op_q == DW'(OPC_MSG))       state_d = S_DESC_RD;
                else if (op_q == DW'(OPC_JUMP)) state_d = S_OP_RD;
                else                            state_d = S_IDLE;
            end
            S_DESC_RD:  state_d = S_DESC_CAP;
            S_DESC_CAP: state_d = last_xfer ? S_START : S_DESC_RD;
            S_START:    state_d = S_WAIT;
            S_WAIT:     if (msg_done) state_d = retry_now ? S_START : S_WB;
            S_WB:       state_d = last_xfer ? S_OP_RD : S_WB;
            default:    state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0; par_q <= '0; idx_q <= '0;
            chan_q <= 1'b0; retried_q <= 1'b0; err_q <= 1'b0;
            for (int i = 0; i < N_DESC_IN; i++) dw_q[i]  <= '0;
            for (int i = 0; i < N_RESULT; i++)  res_q[i] <= '0;
        end else begin
            unique case (state_q)
                S_IDLE:   if (host_go) err_q <= 1'b0;
                S_PAR_RD: op_q <= mem_rdata;
                S_DECODE: begin
                    par_q     <= mem_rdata;
                    idx_q     <= '0;
                    retried_q <= 1'b0;
                    if (!op_known) err_q <= 1'b1;
                end
                S_DESC_CAP: begin
                    dw_q[idx_q] <= mem_rdata;
                    idx_q       <= idx_q + IW'(1);
                    if (last_xfer) chan_q <= dw_q[0][CTL_CHAN];
                end
                S_WAIT: if (msg_done) begin
                    for (int i = 0; i < N_RESULT; i++) res_q[i] <= res_in[i];
                    if (retry_now) begin
                        retried_q <= 1'b1;
                        chan_q    <= ~chan_q;
                    end else begin
                        idx_q <= '0;
                    end
                end
                S_WB:    idx_q <= idx_q + IW'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        msg_start = 1'b0;
        ptr_inc   = 1'b0;
        ptr_jump  = 1'b0;
        jump_val  = mem_rdata[AW-1:0];
        unique case (state_q)
            S_OP_RD:   begin mem_req = 1'b1; mem_addr = ptr; end
            S_PAR_RD:  begin mem_req = 1'b1; mem_addr = ptr + AW'(1); end
            S_DECODE:  ptr_jump = (op_q == DW'(OPC_JUMP));
            S_DESC_RD: begin mem_req = 1'b1; mem_addr = base + AW'(rd_off); end
            S_START:   msg_start = 1'b1;
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base + AW'(wb_off);
                mem_wdata = res_q[idx_q];
                ptr_inc   = last_xfer;
            end
            default: ;
        endcase
    end

    assign desc_out   = dw_q;
    assign msg_chan   = chan_q;
    assign running    = (state_q != S_IDLE);
    assign err        = err_q;
    assign msg_active = (state_q == S_START) || (state_q == S_WAIT);

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_start |=> !msg_start);

    assert_wb_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr - base) inside {AW'(4), AW'(5), AW'(6), AW'(7), AW'(9)}));

    assert_single_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && msg_done && retried_q) |=> (state_q == S_WB));

    assert_err_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !running);
endmodule

// File: rtl/bc_seq_top.sv
module bc_seq_top
    import seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_ptr_we,
    input  logic [AW-1:0] host_ptr_wdata,
    input  logic          host_go,
    output logic [AW-1:0] cur_ptr,
    output logic          running,
    output logic          err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          msg_start,
    output logic [DW-1:0] msg_ctrl,
    output logic [DW-1:0] msg_cmd,
    output logic [DW-1:0] msg_dptr,
    output logic [DW-1:0] msg_ttnm,
    output logic [DW-1:0] msg_cmd2,
    output logic          msg_chan,
    input  logic          msg_done,
    input  logic          msg_fail,
    input  logic [DW-1:0] msg_ttag,
    input  logic [DW-1:0] msg_bstat,
    input  logic [DW-1:0] msg_loop,
    input  logic [DW-1:0] msg_rtstat,
    input  logic [DW-1:0] msg_rtstat2
);
    logic          ptr_inc, ptr_jump, ptr_load, msg_active;
    logic [AW-1:0] jump_val;
    logic [DW-1:0] desc   [N_DESC_IN];
    logic [DW-1:0] res_in [N_RESULT];

    assign res_in[0] = msg_ttag;
    assign res_in[1] = msg_bstat;
    assign res_in[2] = msg_loop;
    assign res_in[3] = msg_rtstat;
    assign res_in[4] = msg_rtstat2;

    assign ptr_load = host_ptr_we && !running;

    seq_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .load(ptr_load), .load_val(host_ptr_wdata),
        .jump(ptr_jump), .jump_val(jump_val),
        .inc(ptr_inc), .ptr(cur_ptr)
    );

    seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .host_go(host_go), .ptr(cur_ptr),
        .mem_rdata(mem_rdata), .msg_done(msg_done), .msg_fail(msg_fail),
        .res_in(res_in), .ptr_inc(ptr_inc), .ptr_jump(ptr_jump),
        .jump_val(jump_val), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .msg_start(msg_start),
        .desc_out(desc), .msg_chan(msg_chan), .running(running), .err(err),
        .msg_active(msg_active)
    );

    assign msg_ctrl = desc[0];
    assign msg_cmd  = desc[1];
    assign msg_dptr = desc[2];
    assign msg_ttnm = desc[3];
    assign msg_cmd2 = desc[4];

    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_active |=> $stable(cur_ptr));

    assert_host_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ptr_we && running && !ptr_inc && !ptr_jump) |=> $stable(cur_ptr));
endmodule

// File: tb/sim_bc_seq_top.sv
module sim_bc_seq_top;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int LAT = 6;
    localparam int NV  = 6;
    // [31:16] control word, [5:4] fail mask per attempt, [3:1] expected starts, [0] final channel
    localparam logic [31:0] VEC [NV] = '{
        {16'h0000, 10'd0, 2'b00, 3'd1, 1'b0},
        {16'h0004, 10'd0, 2'b01, 3'd2, 1'b1},
        {16'h0006, 10'd0, 2'b11, 3'd2, 1'b0},
        {16'h0000, 10'd0, 2'b01, 3'd1, 1'b0},
        {16'h0005, 10'd0, 2'b00, 3'd1, 1'b0},
        {16'h0003, 10'd0, 2'b00, 3'd1, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_ptr_we = 1'b0, host_go = 1'b0;
    logic [AW-1:0] host_ptr_wdata = '0;
    logic [AW-1:0] cur_ptr, mem_addr;
    logic running, err, mem_req, mem_we, msg_start, msg_chan;
    logic [DW-1:0] mem_wdata, mem_rdata, msg_ctrl, msg_cmd, msg_dptr, msg_ttnm, msg_cmd2;
    logic msg_done = 1'b0, msg_fail = 1'b0;
    logic [DW-1:0] msg_ttag, msg_bstat, msg_loop, msg_rtstat, msg_rtstat2;

    logic [DW-1:0] mem [256];
    logic [15:0] start_cnt = 0, cur_id = 0, fail_base = 0;
    logic [1:0]  fail_mask = 2'b00;
    logic [7:0]  cnt = 0;
    logic [DW-1:0] last_ctrl = 0, last_cmd = 0, last_cmd2 = 0, last_ttnm = 0;
    logic last_chan = 1'b0;
    int checks = 0, fails = 0, cyc = 0;

    always #4 clk = ~clk;

    bc_seq_top #(.AW(AW), .DW(DW)) u0 (.*);

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
        else if (mem_req)      mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        msg_done <= 1'b0;
        if (msg_start) begin
            start_cnt <= start_cnt + 1;
            cur_id    <= start_cnt + 1;
            last_ctrl <= msg_ctrl; last_cmd <= msg_cmd; last_cmd2 <= msg_cmd2;
            last_ttnm <= msg_ttnm; last_chan <= msg_chan;
            cnt <= 8'(LAT);
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                msg_done <= 1'b1;
                msg_fail <= (cur_id - fail_base == 1) ? fail_mask[0] : fail_mask[1];
            end
        end
    end

    assign msg_ttag    = {4'h1, cur_id[11:0]};
    assign msg_bstat   = {4'h2, cur_id[11:0]};
    assign msg_loop    = {4'h3, cur_id[11:0]};
    assign msg_rtstat  = {4'h4, cur_id[11:0]};
    assign msg_rtstat2 = {4'h5, cur_id[11:0]};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: actual=%0d cycles expected<100000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [AW-1:0] sp);
        @(negedge clk); host_ptr_we = 1'b1; host_ptr_wdata = sp;
        @(negedge clk); host_ptr_we = 1'b0;
        chk("R1 readback after host write", 32'(cur_ptr), 32'(sp));
        host_go = 1'b1;
        @(negedge clk); host_go = 1'b0;
        chk("R1 running after go", 32'(running), 32'd1);
        for (int k = 0; k < 3000 && running; k++) @(negedge clk);
    endtask

    task automatic put_desc(input logic [7:0] a, input logic [15:0] ctrl);
        mem[a] = ctrl; mem[a+1] = 16'h2C21; mem[a+2] = 16'h0040; mem[a+3] = 16'h0100;
        for (int k = 4; k < 10; k++) mem[a+8'(k)] = 16'hDEAD;
        mem[a+8] = 16'h5555;
    endtask

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset running", 32'(running), 0);
        chk("R9 reset err", 32'(err), 0);
        chk("R1 reset ptr", 32'(cur_ptr), 0);
        chk("R3 reset start", 32'(msg_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 no request when idle", 32'(mem_req), 0);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] ctrl, id;
            logic [2:0] ns;
            ctrl = VEC[i][31:16]; ns = VEC[i][3:1];
            mem[0] = 16'd1; mem[1] = 16'd16; mem[2] = 16'd0; mem[3] = 16'd0;
            put_desc(8'd16, ctrl);
            fail_mask = VEC[i][5:4]; fail_base = start_cnt;
            run(8'd0);
            id = fail_base + 16'(ns);
            chk("R6 start count", 32'(start_cnt - fail_base), 32'(ns));
            chk("R6 final channel", 32'(last_chan), 32'(VEC[i][0]));
            chk("R3 control", 32'(last_ctrl), 32'(ctrl));
            chk("R3 command", 32'(last_cmd), 32'h2C21);
            chk("R3 time to next", 32'(last_ttnm), 32'h0100);
            if (ctrl[0]) chk("R3 second command", 32'(last_cmd2), 32'h5555);
            chk("R5 time tag", 32'(mem[20]), 32'({4'h1, id[11:0]}));
            chk("R5 block status", 32'(mem[21]), 32'({4'h2, id[11:0]}));
            chk("R5 loopback", 32'(mem[22]), 32'({4'h3, id[11:0]}));
            chk("R5 rt status", 32'(mem[23]), 32'({4'h4, id[11:0]}));
            chk("R5 cmd2 untouched", 32'(mem[24]), 32'h5555);
            chk("R5 rt status 2", 32'(mem[25]), ctrl[0] ? 32'({4'h5, id[11:0]}) : 32'hDEAD);
            chk("R8 halt pointer", 32'(cur_ptr), 32'd2);
        end

        // R7 jump, R4 hold during message, R10 ignored host write
        mem[0] = 16'd2; mem[1] = 16'd40;
        mem[40] = 16'd1; mem[41] = 16'd16; mem[42] = 16'd0;
        put_desc(8'd16, 16'h0000);
        fail_mask = 2'b00; fail_base = start_cnt;
        @(negedge clk); host_ptr_wdata = 8'd0; host_ptr_we = 1'b1;
        @(negedge clk); host_ptr_we = 1'b0; host_go = 1'b1;
        @(negedge clk); host_go = 1'b0;
        for (int k = 0; k < 200 && !msg_start; k++) @(negedge clk);
        @(negedge clk);
        chk("R4 pointer held while active", 32'(cur_ptr), 32'd40);
        host_ptr_wdata = 8'd99; host_ptr_we = 1'b1;
        @(negedge clk); host_ptr_we = 1'b0;
        chk("R10 host write ignored", 32'(cur_ptr), 32'd40);
        for (int k = 0; k < 3000 && running; k++) @(negedge clk);
        chk("R7 jump then halt pointer", 32'(cur_ptr), 32'd42);
        chk("R7 message after jump", 32'(start_cnt - fail_base), 32'd1);

        // R11 back-to-back messages
        for (int k = 0; k < 4; k++) begin
            mem[60 + 2*k] = (k < 3) ? 16'd1 : 16'd0;
            mem[61 + 2*k] = 16'd16;
        end
        fail_base = start_cnt;
        run(8'd60);
        chk("R11 three messages", 32'(start_cnt - fail_base), 32'd3);
        chk("R11 final pointer", 32'(cur_ptr), 32'd66);

        // R9 unknown opcode
        mem[80] = 16'd7; mem[81] = 16'd0;
        run(8'd80);
        chk("R9 err set", 32'(err), 32'd1);
        chk("R9 pointer at bad entry", 32'(cur_ptr), 32'd80);
        chk("R9 stopped", 32'(running), 32'd0);
        run(8'd2);
        chk("R9 err cleared by go", 32'(err), 32'd0);
        chk("R8 halt immediately", 32'(cur_ptr), 32'd2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule